// File: doc/BRIEF.md
# Outbound Address Translation Region Table

This block holds a table of outbound windows. Each window maps a range of AXI-side addresses onto a range of PCIe bus addresses. Software programs the table through a simple write port, in which every region owns a fixed 32-byte slot. An address presented on the lookup port selects one region. The block then returns the translated 64-bit bus address and the transaction type that the region carries.

The AXI-side space is split into one large window and a set of equal small windows. Region 0 covers 32 MiB. Regions 1 to 32 each cover 1 MiB. Each region sets how many low address bits pass through unchanged. The programmed base supplies every bit above those. A write whose contents would break the region's rules is refused and flagged, and the region keeps what it held before.

Top module: `oat_xlate`

## Requirements
- R1: After reset every region is unprogrammed. The outputs `xl_valid_o`, `xl_miss_o`, `wr_err_o`, `xl_addr_o` and `xl_type_o` are all zero.
- R2: Lookup address bit 25 selects the region. When bit 25 is 0, the address falls in region 0. When bit 25 is 1, the region is 1 plus bits [24:20].
- R3: The translated address takes bits [N:0] from the lookup address. It takes bits [31:8] from the region's stored low base and bits [63:32] from its stored upper word. N is the stored pass-through field.
- R4: A lookup on a valid region sets `xl_valid_o` in the next cycle. In that same cycle, `xl_type_o` equals bits [3:0] of the region's stored descriptor word.
- R5: A write to word offset 0 carries N in data bits [5:0] and the low base in bits [31:8]. It is refused unless N >= 7. N must also be at most 24 for region 0 and at most 19 for the other regions.
- R6: A write to word offset 8 (the descriptor) is refused unless data bit 23 is set and data bits [3:0] equal 0x2 (memory) or 0x6 (I/O).
- R7: Write byte address = region*32 + word offset. A write is refused if it names a region above 32, a word offset of 16 or more, or an address that is not 4-byte aligned. A refused write changes no region.
- R8: A region is valid only after it has accepted both a word-0 write and a descriptor write. Its upper word (offset 4) accepts any value and is 0 after reset.
- R9: `wr_err_o` is high for exactly the one cycle after a refused write. It stays low after an accepted write. A write to offset 12 is accepted and has no effect.
- R10: A lookup on an invalid region sets `xl_miss_o` in the next cycle. With no lookup, neither `xl_valid_o` nor `xl_miss_o` is set. `xl_addr_o` and `xl_type_o` are zero unless `xl_valid_o` is high.
- R11: A lookup in the same cycle as a write to the region it selects uses the region's contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 11 | Table write byte address |
| wr_data_i | input | 32 | Table write data |
| wr_err_o | output | 1 | Previous write was refused |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 26 | AXI-side lookup address |
| xl_valid_o | output | 1 | Translation result valid |
| xl_miss_o | output | 1 | Lookup hit no valid region |
| xl_addr_o | output | 64 | Translated bus address |
| xl_type_o | output | 4 | Transaction type of the hit region |

## Verification
The bench probes the pass-through limits on both window sizes: N of 6 against 7, 19 against 20 on a small region, and 24 against 25 on region 0. A design with an off-by-one limit or a single shared limit would either accept an oversized window or refuse a legal one, and the next lookup would show it. It also tries region index 33, word offset 16 and misaligned addresses. A decoder that wraps the index or ignores the low bits would overwrite a live region and change later translations. The bench also covers half-programmed regions, where a design missing the two-part valid rule would translate with a zero type. It checks a write and a lookup in the same cycle, where a design that forwards the new write would report a hit one cycle early.

// File: rtl/oat_pkg.sv
package oat_pkg;
  localparam int unsigned NPASS_W = 6;
  localparam int unsigned TYPE_W  = 4;
  localparam logic [TYPE_W-1:0] TYPE_MEM = 4'h2;
  localparam logic [TYPE_W-1:0] TYPE_IO  = 4'h6;

  typedef enum logic [1:0] {
    W_ADDR0 = 2'd0,
    W_ADDR1 = 2'd1,
    W_DESC0 = 2'd2,
    W_DESC1 = 2'd3
  } word_e;

  typedef struct packed {
    logic [NPASS_W-1:0] npass;
    logic [23:0]        lo;
    logic [31:0]        hi;
    logic [TYPE_W-1:0]  ty;
    logic               a0_ok;
    logic               d0_ok;
  } region_t;
endpackage

// File: rtl/oat_wr_check.sv
module oat_wr_check
  import oat_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 33,
  parameter int unsigned SMALL_LOG2  = 20,
  parameter int unsigned BIG_LOG2    = 25,
  parameter int unsigned RIDX_W      = 6,
  parameter int unsigned WA_W        = 11
) (
  input  logic               wr_en_i,
  input  logic [WA_W-1:0]    wr_addr_i,
  input  logic [NPASS_W-1:0] npass_i,
  input  logic               desc_en_i,
  input  logic [TYPE_W-1:0]  ty_i,
  output logic               we_o,
  output logic               reject_o,
  output logic [RIDX_W-1:0]  rsel_o,
  output word_e              word_o
);
  localparam logic [NPASS_W-1:0] LIM_BIG   = NPASS_W'(BIG_LOG2 - 1);
  localparam logic [NPASS_W-1:0] LIM_SMALL = NPASS_W'(SMALL_LOG2 - 1);
  localparam logic [NPASS_W-1:0] MIN_N     = NPASS_W'(7);

  logic in_range, aligned, word_ok, n_ok, d_ok, data_ok;
  logic [NPASS_W-1:0] lim;

  always_comb begin
    rsel_o   = wr_addr_i[WA_W-1:5];
    word_o   = word_e'(wr_addr_i[3:2]);
    in_range = 32'(rsel_o) < NUM_REGIONS;
    aligned  = (wr_addr_i[1:0] == 2'b00);
    word_ok  = !wr_addr_i[4];
    lim      = (rsel_o == '0) ? LIM_BIG : LIM_SMALL;
    n_ok     = (npass_i >= MIN_N) && (npass_i <= lim);
    d_ok     = desc_en_i && ((ty_i == TYPE_MEM) || (ty_i == TYPE_IO));
    case (word_o)
      W_ADDR0: data_ok = n_ok;
      W_DESC0: data_ok = d_ok;
      default: data_ok = 1'b1;
    endcase
    we_o     = wr_en_i && in_range && aligned && word_ok && data_ok;
    reject_o = wr_en_i && !(in_range && aligned && word_ok && data_ok);
  end
endmodule

// File: rtl/oat_table.sv
module oat_table
  import oat_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 33,
  parameter int unsigned RIDX_W      = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [RIDX_W-1:0]            rsel_i,
  input  word_e                        word_i,
  input  logic [31:0]                  data_i,
  output region_t [NUM_REGIONS-1:0]    tbl_o
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_o[g] <= '0;
      end else if (we_i && rsel_i == RIDX_W'(g)) begin
        case (word_i)
          W_ADDR0: begin
            tbl_o[g].npass <= data_i[NPASS_W-1:0];
            tbl_o[g].lo    <= data_i[31:8];
            tbl_o[g].a0_ok <= 1'b1;
          end
          W_ADDR1: tbl_o[g].hi <= data_i;
          W_DESC0: begin
            tbl_o[g].ty    <= data_i[TYPE_W-1:0];
            tbl_o[g].d0_ok <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/oat_lookup.sv
module oat_lookup
  import oat_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 33,
  parameter int unsigned SMALL_LOG2  = 20,
  parameter int unsigned BIG_LOG2    = 25,
  parameter int unsigned AXI_AW      = 26,
  parameter int unsigned RIDX_W      = 6
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  region_t [NUM_REGIONS-1:0] tbl_i,
  input  logic                      lk_valid_i,
  input  logic [AXI_AW-1:0]         lk_addr_i,
  output logic                      xl_valid_o,
  output logic                      xl_miss_o,
  output logic [63:0]               xl_addr_o,
  output logic [TYPE_W-1:0]         xl_type_o
);
  logic [RIDX_W-1:0] rsel;
  region_t           ent;
  logic              hit;
  logic [6:0]        sh;
  logic [63:0]       mask, base, xl;

  always_comb begin
    rsel = lk_addr_i[AXI_AW-1]
         ? RIDX_W'(lk_addr_i[BIG_LOG2-1:SMALL_LOG2]) + RIDX_W'(1)
         : '0;
    ent  = tbl_i[rsel];
    hit  = ent.a0_ok && ent.d0_ok;
    sh   = {1'b0, ent.npass} + 7'd1;
    mask = (64'd1 << sh) - 64'd1;
    base = {ent.hi, ent.lo, 8'h00};
    xl   = (64'(lk_addr_i) & mask) | (base & ~mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xl_valid_o <= 1'b0;
      xl_miss_o  <= 1'b0;
      xl_addr_o  <= '0;
      xl_type_o  <= '0;
    end else begin
      xl_valid_o <= lk_valid_i && hit;
      xl_miss_o  <= lk_valid_i && !hit;
      xl_addr_o  <= (lk_valid_i && hit) ? xl : '0;
      xl_type_o  <= (lk_valid_i && hit) ? ent.ty : '0;
    end
  end
endmodule

// File: rtl/oat_xlate.sv
module oat_xlate
  import oat_pkg::*;
#(
  parameter int unsigned SMALL_LOG2  = 20,
  parameter int unsigned SMALL_IDX_W = 5,
  localparam int unsigned NUM_REGIONS = (1 << SMALL_IDX_W) + 1,
  localparam int unsigned BIG_LOG2    = SMALL_LOG2 + SMALL_IDX_W,
  localparam int unsigned AXI_AW      = BIG_LOG2 + 1,
  localparam int unsigned RIDX_W      = $clog2(NUM_REGIONS),
  localparam int unsigned WA_W        = RIDX_W + 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WA_W-1:0]   wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              wr_err_o,
  input  logic              lk_valid_i,
  input  logic [AXI_AW-1:0] lk_addr_i,
  output logic              xl_valid_o,
  output logic              xl_miss_o,
  output logic [63:0]       xl_addr_o,
  output logic [3:0]        xl_type_o
);
  logic                      we, reject;
  logic [RIDX_W-1:0]         rsel;
  word_e                     word;
  region_t [NUM_REGIONS-1:0] tbl;

  oat_wr_check #(
    .NUM_REGIONS(NUM_REGIONS), .SMALL_LOG2(SMALL_LOG2), .BIG_LOG2(BIG_LOG2),
    .RIDX_W(RIDX_W), .WA_W(WA_W)
  ) u_check (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .npass_i  (wr_data_i[NPASS_W-1:0]),
    .desc_en_i(wr_data_i[23]),
    .ty_i     (wr_data_i[TYPE_W-1:0]),
    .we_o     (we),
    .reject_o (reject),
    .rsel_o   (rsel),
    .word_o   (word)
  );

  oat_table #(.NUM_REGIONS(NUM_REGIONS), .RIDX_W(RIDX_W)) u_table (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we),
    .rsel_i(rsel),
    .word_i(word),
    .data_i(wr_data_i),
    .tbl_o (tbl)
  );

  oat_lookup #(
    .NUM_REGIONS(NUM_REGIONS), .SMALL_LOG2(SMALL_LOG2), .BIG_LOG2(BIG_LOG2),
    .AXI_AW(AXI_AW), .RIDX_W(RIDX_W)
  ) u_lookup (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tbl_i     (tbl),
    .lk_valid_i(lk_valid_i),
    .lk_addr_i (lk_addr_i),
    .xl_valid_o(xl_valid_o),
    .xl_miss_o (xl_miss_o),
    .xl_addr_o (xl_addr_o),
    .xl_type_o (xl_type_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_o <= 1'b0;
    else         wr_err_o <= reject;
  end
endmodule

// File: rtl/oat_xlate_chk.sv
module oat_xlate_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_err_o,
  input logic       lk_valid_i,
  input logic [7:0] lk_lo_i,
  input logic       xl_valid_o,
  input logic       xl_miss_o,
  input logic [7:0] xl_lo_o,
  input logic [3:0] xl_type_o
);
  assert_valid_miss_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xl_valid_o && xl_miss_o));

  assert_lookup_answered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (xl_valid_o || xl_miss_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> (!xl_valid_o && !xl_miss_o));

  assert_err_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !wr_err_o);

  assert_low_bits_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (!xl_valid_o || xl_lo_o == $past(lk_lo_i)));

  assert_type_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_valid_o |-> (xl_type_o == 4'h2 || xl_type_o == 4'h6));
endmodule

bind oat_xlate oat_xlate_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_err_o  (wr_err_o),
  .lk_valid_i(lk_valid_i),
  .lk_lo_i   (lk_addr_i[7:0]),
  .xl_valid_o(xl_valid_o),
  .xl_miss_o (xl_miss_o),
  .xl_lo_o   (xl_addr_o[7:0]),
  .xl_type_o (xl_type_o)
);

// File: tb/tb_oat_xlate.sv
module tb_oat_xlate;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [10:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        wr_err_o;
  logic        lk_valid_i = 1'b0;
  logic [25:0] lk_addr_i = '0;
  logic        xl_valid_o, xl_miss_o;
  logic [63:0] xl_addr_o;
  logic [3:0]  xl_type_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [5:0]  m_n  [33];
  logic [23:0] m_lo [33];
  logic [31:0] m_hi [33];
  logic [3:0]  m_ty [33];
  bit          m_a0 [33];
  bit          m_d0 [33];

  always #2.5 clk = ~clk;

  oat_xlate dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .wr_err_o(wr_err_o), .lk_valid_i(lk_valid_i),
    .lk_addr_i(lk_addr_i), .xl_valid_o(xl_valid_o), .xl_miss_o(xl_miss_o),
    .xl_addr_o(xl_addr_o), .xl_type_o(xl_type_o)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legal(int unsigned ba, logic [31:0] d);
    int unsigned r = ba >> 5;
    int unsigned w = (ba >> 2) & 7;
    if ((ba & 3) != 0 || r > 32 || w > 3) return 1'b0;
    if (w == 0) return (d[5:0] >= 7) && (d[5:0] <= ((r == 0) ? 24 : 19));
    if (w == 2) return d[23] && (d[3:0] == 4'h2 || d[3:0] == 4'h6);
    return 1'b1;
  endfunction

  function automatic void model_wr(int unsigned ba, logic [31:0] d);
    int unsigned r = ba >> 5;
    int unsigned w = (ba >> 2) & 7;
    if (!legal(ba, d)) return;
    case (w)
      0: begin m_n[r] = d[5:0]; m_lo[r] = d[31:8]; m_a0[r] = 1'b1; end
      1: m_hi[r] = d;
      2: begin m_ty[r] = d[3:0]; m_d0[r] = 1'b1; end
      default: ;
    endcase
  endfunction

  function automatic int unsigned region_of(logic [25:0] a);
    return a[25] ? 1 + int'(a[24:20]) : 0;
  endfunction

  function automatic logic [63:0] exp_addr(logic [25:0] a);
    int unsigned r = region_of(a);
    logic [63:0] res = {m_hi[r], m_lo[r], 8'h00};
    for (int i = 0; i <= int'(m_n[r]); i++) res[i] = (i < 26) ? a[i] : 1'b0;
    return res;
  endfunction

  task automatic wr(int unsigned ba, logic [31:0] d, string req);
    bit exp_err = !legal(ba, d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 11'(ba); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(wr_err_o == exp_err, req, 64'(wr_err_o), 64'(exp_err));
    model_wr(ba, d);
  endtask

  task automatic look(logic [25:0] a, string req);
    int unsigned r = region_of(a);
    bit hit = m_a0[r] && m_d0[r];
    @(negedge clk);
    lk_valid_i = 1'b1; lk_addr_i = a;
    @(negedge clk);
    lk_valid_i = 1'b0;
    chk(xl_valid_o == hit && xl_miss_o == !hit, req, {xl_valid_o, xl_miss_o}, {hit, !hit});
    if (hit) begin
      chk(xl_addr_o == exp_addr(a), req, xl_addr_o, exp_addr(a));
      chk(xl_type_o == m_ty[r], req, 64'(xl_type_o), 64'(m_ty[r]));
    end else begin
      chk(xl_addr_o == '0 && xl_type_o == '0, req, xl_addr_o, 64'd0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 33; i++) begin
      m_n[i] = '0; m_lo[i] = '0; m_hi[i] = '0; m_ty[i] = '0; m_a0[i] = 0; m_d0[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(!xl_valid_o && !xl_miss_o && !wr_err_o && xl_addr_o == 0 && xl_type_o == 0,
        "R1 reset outputs", {xl_valid_o, xl_miss_o, wr_err_o}, 64'd0);
    rst_ni = 1'b1;
    look(26'h0000123, "R1 miss after reset");

    // region 0, widest legal window
    wr(0, {24'h123456, 2'b00, 6'd24}, "R5 region0 N=24 accepted");
    look(26'h0ABCDEF, "R8 half programmed region0");
    wr(4, 32'hDEADBEEF, "R8 upper word");
    wr(8, 32'h0080_0002, "R6 mem type");
    look(26'h1ABCDEF, "R3 region0 translate");
    look(26'h0000000, "R2 region0 low edge");
    wr(0, {24'hFFFFFF, 2'b00, 6'd25}, "R5 region0 N=25 refused");
    look(26'h1FFFFFF, "R5 region0 unchanged");

    // small region 5 = addr[24:20]=4
    wr(5*32, {24'hA5A5A5, 2'b00, 6'd20}, "R5 small N=20 refused");
    wr(5*32, {24'hA5A5A5, 2'b00, 6'd6}, "R5 N=6 refused");
    wr(5*32, {24'hA5A5A5, 2'b00, 6'd19}, "R5 small N=19 accepted");
    wr(5*32 + 8, 32'h0000_0006, "R6 missing enable bit refused");
    wr(5*32 + 8, 32'h0080_0003, "R6 bad type refused");
    look(26'h24ABCDE, "R8 desc not yet accepted");
    wr(5*32 + 8, 32'h0080_0006, "R6 io type");
    look(26'h24ABCDE, "R2 R4 region5 io");
    wr(5*32, {24'h0F0F0F, 2'b00, 6'd7}, "R5 N=7 accepted");
    look(26'h24FFFFF, "R3 narrow pass-through");

    // decode
    wr(33*32, {24'h111111, 2'b00, 6'd10}, "R7 region 33 refused");
    wr(5*32 + 16, 32'h0080_0002, "R7 offset 16 refused");
    wr(5*32 + 9, 32'h0080_0002, "R7 misaligned refused");
    wr(5*32 + 12, 32'hFFFF_FFFF, "R9 desc1 accepted no effect");
    look(26'h24FFFFF, "R7 R9 region5 unchanged");

    // idle: no lookup
    @(negedge clk);
    @(negedge clk);
    chk(!xl_valid_o && !xl_miss_o, "R10 idle quiet", {xl_valid_o, xl_miss_o}, 64'd0);

    // same-cycle write and lookup on region 9 (addr[24:20]=8)
    wr(9*32, {24'h777777, 2'b00, 6'd15}, "R11 setup");
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 11'(9*32 + 8); wr_data_i = 32'h0080_0002;
    lk_valid_i = 1'b1; lk_addr_i = 26'h2812345;
    @(negedge clk);
    wr_en_i = 1'b0; lk_valid_i = 1'b0;
    chk(xl_miss_o && !xl_valid_o, "R11 old contents used", {xl_valid_o, xl_miss_o}, 64'd1);
    model_wr(9*32 + 8, 32'h0080_0002);
    look(26'h2812345, "R11 hit after write");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int unsigned r = $urandom_range(0, 36);
      int unsigned w = $urandom_range(0, 4);
      int unsigned ba = r * 32 + w * 4 + (($urandom_range(0, 15) == 0) ? 2 : 0);
      logic [31:0] d = $urandom;
      if (w == 0) d[5:0] = 6'($urandom_range(4, 27));
      if (w == 2) begin
        d[23] = ($urandom_range(0, 3) != 0);
        d[3:0] = ($urandom_range(0, 3) == 0) ? 4'($urandom) : (($urandom_range(0, 1) != 0) ? 4'h2 : 4'h6);
      end
      wr(ba, d, "R5 R6 R7 random write");
      look(26'($urandom), "R2 R3 R4 R10 random lookup");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule